// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block narrows a 32-bit IEEE-754 binary32 word to a 16-bit binary16 word using round-to-nearest, ties-to-even. It is a combinational conversion datapath followed by one register stage. An input word is accepted with a valid strobe, and the converted word appears one clock later together with its own valid strobe.

Every input class has a defined result. Zero and binary32 subnormals become a signed zero. Infinities pass through. NaNs keep their upper payload bits and always stay NaN. Magnitudes too large for binary16 saturate to infinity. Magnitudes below the smallest binary16 normal are rounded into the binary16 subnormal range. When rounding carries out of the mantissa, the result moves up one binade, and this can reach infinity.

The field widths of both formats are parameters. Their defaults are 8/23 for the input and 5/10 for the output.

Top module: `f2h_conv`

## Requirements
- R1: Input fields are sign bit 31, exponent bits 30:23 and mantissa bits 22:0. Output fields are sign bit 15, exponent bits 14:10 and mantissa bits 9:0. The output sign always equals the input sign.
- R2: An input exponent code of 0 gives output exponent 0 and mantissa 0 (a signed zero), whatever the input mantissa is.
- R3: Input exponent 255 with mantissa 0 gives output exponent 31 and mantissa 0 (0x7C00 or 0xFC00).
- R4: Input exponent 255 with a nonzero mantissa gives output exponent 31, and the output mantissa is input mantissa bits 22:13. If those bits are all zero, the output mantissa is 1.
- R5: Input exponent codes 143 to 254 give a signed infinity.
- R6: Input exponent codes 113 to 142 give output exponent (code − 112). The output mantissa is input mantissa / 2^13, rounded to nearest with ties to even.
- R7: Input exponent codes 1 to 112 give output exponent 0. The output mantissa is |x|·2^24 rounded to nearest, ties to even. This can give zero, a subnormal, or 0x0400.
- R8: A rounded mantissa of 1024 clears the mantissa and adds one to the exponent. Exponent 30 therefore becomes infinity (0x477FF000 gives 0x7C00), and the top of the subnormal range gives 0x0400.
- R9: out_valid equals in_valid from one cycle earlier. out_word takes the result one cycle after an accepted input and holds its value while in_valid is low.
- R10: A synchronous active-high reset clears out_valid and out_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_word | input | EXP_IN+MAN_IN+1 | binary32 input |
| out_valid | output | 1 | Output word is valid |
| out_word | output | EXP_OUT+MAN_OUT+1 | binary16 result |

## Verification
The bench builds the block with its default widths: 8/23 at the input and 5/10 at the output. These widths make every one of the 256 input exponent codes reachable as a sweep. Each code is crossed with both signs and with mantissa patterns that sit exactly on, just below and just above a rounding tie. This places every class boundary (113, 142/143, 255), every subnormal shift distance including shifts past 24 bits, and both carry-into-exponent cases inside the sweep. A long pseudo-random stream then covers the mantissa bits between those patterns. All results are compared against an integer model of the rounding rule.

// File: rtl/f2h_pkg.sv
package f2h_pkg;

    // Input classes, decided from the exponent and mantissa fields
    typedef enum logic [2:0] {
        CLS_ZERO,   // exponent code 0 (zero or subnormal)
        CLS_INF,    // all-ones exponent, zero mantissa
        CLS_NAN,    // all-ones exponent, nonzero mantissa
        CLS_OVF,    // finite, above the output range
        CLS_NORM,   // maps to an output normal
        CLS_SUB     // below the output normal range
    } cls_e;

endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
    import f2h_pkg::*;
#(
    parameter int EXP_IN  = 8,
    parameter int MAN_IN  = 23,
    parameter int EXP_OUT = 5
) (
    input  logic [EXP_IN-1:0] in_exp,
    input  logic [MAN_IN-1:0] in_man,
    output cls_e              cls
);
    localparam int BIAS_IN  = (1 << (EXP_IN - 1)) - 1;
    localparam int BIAS_OUT = (1 << (EXP_OUT - 1)) - 1;
    localparam logic [EXP_IN-1:0] OVF_LIM = EXP_IN'(BIAS_IN + BIAS_OUT);
    localparam logic [EXP_IN-1:0] SUB_LIM = EXP_IN'(BIAS_IN - BIAS_OUT + 1);

    always_comb begin
        if (in_exp == '0)
            cls = CLS_ZERO;
        else if (in_exp == '1)
            cls = (in_man == '0) ? CLS_INF : CLS_NAN;
        else if (in_exp > OVF_LIM)
            cls = CLS_OVF;
        else if (in_exp < SUB_LIM)
            cls = CLS_SUB;
        else
            cls = CLS_NORM;
    end
endmodule

// File: rtl/f2h_align.sv
module f2h_align
    import f2h_pkg::*;
#(
    parameter int EXP_IN  = 8,
    parameter int MAN_IN  = 23,
    parameter int EXP_OUT = 5,
    parameter int MAN_OUT = 10
) (
    input  cls_e               cls,
    input  logic [EXP_IN-1:0]  in_exp,
    input  logic [MAN_IN-1:0]  in_man,
    output logic [MAN_OUT:0]   kept,
    output logic               guard,
    output logic               sticky,
    output logic [EXP_OUT-1:0] exp_base
);
    localparam int BIAS_IN  = (1 << (EXP_IN - 1)) - 1;
    localparam int BIAS_OUT = (1 << (EXP_OUT - 1)) - 1;
    localparam int SIGW     = MAN_IN + 1;
    localparam int DROP     = MAN_IN - MAN_OUT;
    localparam int SH_BASE  = BIAS_IN - BIAS_OUT + 1 + DROP;
    localparam int SH_MAX   = SIGW + 1;

    logic [SIGW-1:0] sig;
    logic [SIGW-1:0] frac;
    int              sh;

    assign sig = {1'b1, in_man};

    always_comb begin
        kept     = '0;
        guard    = 1'b0;
        sticky   = 1'b0;
        exp_base = '0;
        sh       = 0;
        frac     = '0;
        case (cls)
            CLS_NORM: begin
                kept     = {1'b0, in_man[MAN_IN-1:DROP]};
                guard    = in_man[DROP-1];
                sticky   = |in_man[DROP-2:0];
                exp_base = EXP_OUT'(int'(in_exp) - (BIAS_IN - BIAS_OUT));
            end
            CLS_SUB: begin
                // Shift the whole significand (hidden 1 included) into the
                // subnormal grid, then clamp: beyond SH_MAX everything is
                // below half an output ulp.
                sh = SH_BASE - int'(in_exp);
                if (sh > SH_MAX)
                    sh = SH_MAX;
                kept   = (MAN_OUT + 1)'(sig >> sh);
                frac   = SIGW'({sig, {SIGW{1'b0}}} >> sh);
                guard  = frac[SIGW-1];
                sticky = |frac[SIGW-2:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/f2h_rne.sv
module f2h_rne #(
    parameter int MAN_OUT = 10
) (
    input  logic [MAN_OUT:0] kept,
    input  logic             guard,
    input  logic             sticky,
    output logic [MAN_OUT:0] rounded
);
    logic bump;

    // Round up only above the half-way point, or exactly on it with an odd LSB
    assign bump    = guard & (sticky | kept[0]);
    assign rounded = kept + (MAN_OUT + 1)'(bump);
endmodule

// File: rtl/f2h_conv.sv
module f2h_conv
    import f2h_pkg::*;
#(
    parameter int EXP_IN  = 8,
    parameter int MAN_IN  = 23,
    parameter int EXP_OUT = 5,
    parameter int MAN_OUT = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [EXP_IN+MAN_IN:0]     in_word,
    output logic                       out_valid,
    output logic [EXP_OUT+MAN_OUT:0]   out_word
);
    localparam int IW   = EXP_IN + MAN_IN + 1;
    localparam int OW   = EXP_OUT + MAN_OUT + 1;
    localparam int DROP = MAN_IN - MAN_OUT;

    typedef struct packed {
        logic          vld;
        logic [OW-1:0] word;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic               sgn;
    logic [EXP_IN-1:0]  exp_in;
    logic [MAN_IN-1:0]  man_in;
    logic [MAN_OUT-1:0] nan_man;
    cls_e               cls;
    logic [MAN_OUT:0]   kept;
    logic [MAN_OUT:0]   rounded;
    logic               guard;
    logic               sticky;
    logic [EXP_OUT-1:0] exp_base;
    logic [OW-1:0]      result;

    assign sgn     = in_word[IW-1];
    assign exp_in  = in_word[IW-2:MAN_IN];
    assign man_in  = in_word[MAN_IN-1:0];
    assign nan_man = man_in[MAN_IN-1:DROP];

    f2h_classify #(
        .EXP_IN (EXP_IN),
        .MAN_IN (MAN_IN),
        .EXP_OUT(EXP_OUT)
    ) u_classify (
        .in_exp(exp_in),
        .in_man(man_in),
        .cls   (cls)
    );

    f2h_align #(
        .EXP_IN (EXP_IN),
        .MAN_IN (MAN_IN),
        .EXP_OUT(EXP_OUT),
        .MAN_OUT(MAN_OUT)
    ) u_align (
        .cls     (cls),
        .in_exp  (exp_in),
        .in_man  (man_in),
        .kept    (kept),
        .guard   (guard),
        .sticky  (sticky),
        .exp_base(exp_base)
    );

    f2h_rne #(
        .MAN_OUT(MAN_OUT)
    ) u_rne (
        .kept   (kept),
        .guard  (guard),
        .sticky (sticky),
        .rounded(rounded)
    );

    always_comb begin
        case (cls)
            CLS_ZERO: result = {sgn, {(OW-1){1'b0}}};
            CLS_INF,
            CLS_OVF:  result = {sgn, {EXP_OUT{1'b1}}, {MAN_OUT{1'b0}}};
            CLS_NAN: begin
                if (nan_man == '0)
                    result = {sgn, {EXP_OUT{1'b1}}, MAN_OUT'(1)};
                else
                    result = {sgn, {EXP_OUT{1'b1}}, nan_man};
            end
            default: begin
                // A carry into bit MAN_OUT means the next binade
                if (rounded[MAN_OUT])
                    result = {sgn, exp_base + EXP_OUT'(1), {MAN_OUT{1'b0}}};
                else
                    result = {sgn, exp_base, rounded[MAN_OUT-1:0]};
            end
        endcase

        pipe_d.vld  = in_valid;
        pipe_d.word = in_valid ? result : pipe_q.word;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pipe_q <= '0;
        else
            pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.vld;
    assign out_word  = pipe_q.word;
endmodule

// File: rtl/f2h_conv_chk.sv
module f2h_conv_chk #(
    parameter int EXP_IN  = 8,
    parameter int MAN_IN  = 23,
    parameter int EXP_OUT = 5,
    parameter int MAN_OUT = 10
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [EXP_IN+MAN_IN:0]   in_word,
    input logic                     out_valid,
    input logic [EXP_OUT+MAN_OUT:0] out_word
);
    localparam int IW       = EXP_IN + MAN_IN + 1;
    localparam int OW       = EXP_OUT + MAN_OUT + 1;
    localparam int BIAS_IN  = (1 << (EXP_IN - 1)) - 1;
    localparam int BIAS_OUT = (1 << (EXP_OUT - 1)) - 1;

    logic [EXP_IN-1:0]  e_in;
    logic [MAN_IN-1:0]  m_in;
    logic [EXP_OUT-1:0] e_out;
    logic [MAN_OUT-1:0] m_out;
    logic [EXP_OUT-1:0] e_guess;
    logic               is_sub;
    logic               is_norm;
    logic               is_ovf;

    assign e_in    = in_word[IW-2:MAN_IN];
    assign m_in    = in_word[MAN_IN-1:0];
    assign e_out   = out_word[OW-2:MAN_OUT];
    assign m_out   = out_word[MAN_OUT-1:0];
    assign e_guess = EXP_OUT'(int'(e_in) - (BIAS_IN - BIAS_OUT));
    assign is_sub  = (e_in != '0) && (int'(e_in) < BIAS_IN - BIAS_OUT + 1);
    assign is_norm = (int'(e_in) >= BIAS_IN - BIAS_OUT + 1) && (int'(e_in) <= BIAS_IN + BIAS_OUT);
    assign is_ovf  = (int'(e_in) > BIAS_IN + BIAS_OUT) && (e_in != '1);

    p_sign_keep_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_word[OW-1] == $past(in_word[IW-1]));

    p_sub_flush_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && e_in == '0) |=> (e_out == '0 && m_out == '0));

    p_inf_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && e_in == '1 && m_in == '0) |=> (e_out == '1 && m_out == '0));

    p_nan_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && e_in == '1 && m_in != '0) |=> (e_out == '1 && m_out != '0));

    p_ovf_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_ovf) |=> (e_out == '1 && m_out == '0));

    p_sub_range_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_sub) |=> (int'(e_out) <= 1));

    p_norm_exp_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_norm) |=>
            (e_out == $past(e_guess) || e_out == $past(e_guess) + EXP_OUT'(1)));

    p_valid_lag_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_bubble_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_word)));
endmodule

bind f2h_conv f2h_conv_chk #(
    .EXP_IN (EXP_IN),
    .MAN_IN (MAN_IN),
    .EXP_OUT(EXP_OUT),
    .MAN_OUT(MAN_OUT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_word  (in_word),
    .out_valid(out_valid),
    .out_word (out_word)
);

// File: tb/tb_f2h_conv.sv
`timescale 1ns/1ps
module tb_f2h_conv;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [15:0] out_word;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [31:0] lfsr = 32'h1BADC0DE;

    f2h_conv dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_word  (in_word),
        .out_valid(out_valid),
        .out_word (out_word)
    );

    always #5 clk = ~clk;

    // Integer model of the conversion rules
    function automatic logic [15:0] ref_h(input logic [31:0] w);
        logic  s;
        int    e;
        longint m, sig, whole, rem, half, val;
        int    d;
        s = w[31];
        e = int'(w[30:23]);
        m = longint'(w[22:0]);
        if (e == 0) return {s, 15'h0};
        if (e == 255) begin
            if (m == 0) return {s, 5'h1f, 10'h0};
            val = m >> 13;
            if (val == 0) val = 1;
            return {s, 5'h1f, val[9:0]};
        end
        if (e > 142) return {s, 5'h1f, 10'h0};
        sig = m + (longint'(1) << 23);
        d = (e >= 113) ? 13 : 126 - e;
        if (d > 40) whole = 0;
        else begin
            whole = sig >> d;
            rem   = sig - (whole << d);
            half  = longint'(1) << (d - 1);
            if (rem > half || (rem == half && whole[0])) whole = whole + 1;
        end
        if (e >= 113) val = (longint'(e - 112) << 10) + whole - 1024;
        else          val = whole;
        return {s, val[14:0]};
    endfunction

    function automatic string tag_of(input logic [31:0] w);
        int e;
        e = int'(w[30:23]);
        if (e == 0)   return "R2";
        if (e == 255) return (w[22:0] == 0) ? "R3" : "R4";
        if (e > 142)  return "R5";
        if (e >= 113) return "R6";
        return "R7";
    endfunction

    function automatic logic [22:0] pattern(input int i, input logic [31:0] rnd);
        case (i)
            0:  return 23'h000000;
            1:  return 23'h000001;
            2:  return 23'h7FFFFF;
            3:  return 23'h400000;
            4:  return 23'h001000;
            5:  return 23'h002000;
            6:  return 23'h003000;
            7:  return 23'h001001;
            8:  return 23'h7FF000;
            9:  return 23'h7FE000;
            10: return 23'h7FEFFF;
            11: return 23'h000FFF;
            12: return 23'h001FFF;
            13: return 23'h555555;
            14: return 23'h2AAAAA;
            15: return 23'h003FFF;
            default: return rnd[22:0];
        endcase
    endfunction

    task automatic step_lfsr();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One vector per cycle: drive at the falling edge, sample after the rise
    task automatic convert(input logic [31:0] w, input string tag);
        @(negedge clk);
        in_word  = w;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        check(tag, $sformatf("valid for %h", w), 32'(out_valid), 32'd1);
        check(tag, $sformatf("word for %h", w), 32'(out_word), 32'(ref_h(w)));
    endtask

    task automatic expect_word(input logic [31:0] w, input logic [15:0] h, input string tag);
        @(negedge clk);
        in_word  = w;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        check(tag, $sformatf("directed %h", w), 32'(out_word), 32'(h));
    endtask

    initial begin
        logic [15:0] held;
        repeat (3) @(posedge clk);
        #1;
        check("R10", "out_valid after reset", 32'(out_valid), 32'd0);
        check("R10", "out_word after reset", 32'(out_word), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // Directed corner values
        expect_word(32'h80000001, 16'h8000, "R2");
        expect_word(32'h00000000, 16'h0000, "R2");
        expect_word(32'hFF800000, 16'hFC00, "R3");
        expect_word(32'h7F800001, 16'h7C01, "R4");
        expect_word(32'hFFC00000, 16'hFE00, "R4");
        expect_word(32'h47800000, 16'h7C00, "R5");
        expect_word(32'h3F801000, 16'h3C00, "R6");
        expect_word(32'h3F803000, 16'h3C02, "R6");
        expect_word(32'h33000000, 16'h0000, "R7");
        expect_word(32'h33000001, 16'h0001, "R7");
        expect_word(32'h33800000, 16'h0001, "R7");
        expect_word(32'h477FF000, 16'h7C00, "R8");
        expect_word(32'h387FF000, 16'h0400, "R8");
        expect_word(32'h3F7FF000, 16'h3C00, "R8");
        expect_word(32'hC0490FDB, 16'hC248, "R1");

        // Bubble: valid drops, word holds
        held = out_word;
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = 32'h3F800000;
        @(posedge clk);
        #1;
        check("R9", "out_valid on bubble", 32'(out_valid), 32'd0);
        check("R9", "out_word holds on bubble", 32'(out_word), 32'(held));

        // Sweep: every exponent code, both signs, tie-sensitive mantissas
        for (int e = 0; e < 256; e++) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 32; p++) begin
                    logic [31:0] w;
                    step_lfsr();
                    w = {s[0], e[7:0], pattern(p, lfsr)};
                    convert(w, tag_of(w));
                end
            end
        end

        // Random stream
        for (int i = 0; i < 30000; i++) begin
            step_lfsr();
            convert(lfsr, tag_of(lfsr));
        end

        // Reset in the middle of traffic
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b1;
        in_word  = 32'h3F800000;
        @(posedge clk);
        #1;
        check("R10", "out_valid under reset", 32'(out_valid), 32'd0);
        check("R10", "out_word under reset", 32'(out_word), 32'd0);
        @(negedge clk);
        rst      = 1'b0;
        in_valid = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule